// File: doc/BRIEF.md
# Region-Based Bus Access Firewall

This block screens every access aimed at a peripheral's register space. It holds a small set of programmable address windows. Each window has an inclusive lower and upper address, a control word with an enable flag and a background flag, and up to three permission slots. Each slot names one initiator privilege ID and the access rights that ID holds inside the window. An access arrives with its address, initiator ID, direction, secure/non-secure attribute, privileged/user attribute, and cacheable and debug qualifiers. One cycle later the block answers with either a grant, which lets the access through to the peripheral, or an error response.

Windows may overlap. A window whose background flag is clear is a foreground window. When an address falls in any foreground window, only the permissions of the winning foreground window count, and any background window under it is ignored. Among overlapping windows of the same kind, the lowest-numbered one wins. An address that lands in no enabled window is refused. The first refused access is frozen in a violation record, and the record stays until software clears it.

Windows are programmed through a plain single-cycle write port: a window index, a field code and a data word. A write to a window or field that does not exist is refused, and the port flags it.

Top module: `bus_region_firewall`

## Requirements
- R1: After reset every window is disabled and the violation record is empty, so every access is refused.
- R2: An access presented with `req_valid` high in cycle k is answered in cycle k+1 with `dec_valid` high and exactly one of `dec_grant` and `dec_err` high. With no access, all three are low.
- R3: A window covers its lower address, its upper address and every address between them, and nothing outside that range.
- R4: A slot word carries the initiator ID in bits 23:16 and the rights in bits 15:0. An access is granted only if some slot of the deciding window holds its initiator ID and suitable rights. Any one of the slots is enough.
- R5: The rights field is four nibbles: bits 3:0 secure-privileged, 7:4 secure-user, 11:8 non-secure-privileged, 15:12 non-secure-user. Within a nibble, bit 0 is write, bit 1 is read, bit 2 is cacheable and bit 3 is debug. An access needs the write or read bit of the nibble its attributes select, and also the cacheable bit if it is cacheable and the debug bit if it is a debug access.
- R6: A hit in an enabled foreground window (control bit 1 clear) is decided by that window alone, and any background window (control bit 1 set) that also covers the address is ignored.
- R7: Among overlapping foreground windows, the lowest-numbered one decides. Among background windows hit with no foreground hit, the lowest-numbered one decides.
- R8: A window with enable (control bit 0) clear matches nothing. An access that hits no enabled window is refused.
- R9: A configuration write takes effect for accesses presented in the cycle after the write. An access presented in the same cycle as the write is judged on the old settings.
- R10: Field codes are 0 lower address, 1 upper address, 2 control, and 3+s for slot s. A write whose window index is at or above the window count, or whose field code is at or above 3 plus the slot count, changes nothing and raises `cfg_err` in the next cycle. An accepted write leaves `cfg_err` low.
- R11: A refused access is recorded (address, ID, direction, secure and privileged attributes) on the same edge that produces its answer, but only if the record is empty. Later refusals leave the record unchanged.
- R12: `log_clear` empties the record. A refusal answered on the same edge as a clear is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration and decisions |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | CFG_IDX_W | Window index of the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | DATA_W | Write data |
| cfg_err | output | 1 | The previous cycle's write was refused |
| req_valid | input | 1 | Access present |
| req_addr | input | ADDR_W | Access address |
| req_id | input | 8 | Initiator privilege ID |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_cache | input | 1 | Cacheable access |
| req_debug | input | 1 | Debug access |
| dec_valid | output | 1 | Answer present |
| dec_grant | output | 1 | Access allowed to the peripheral |
| dec_err | output | 1 | Error response for a refused access |
| log_clear | input | 1 | Empty the violation record |
| log_valid | output | 1 | Violation record holds an entry |
| log_addr | output | ADDR_W | Recorded address |
| log_id | output | 8 | Recorded initiator ID |
| log_write | output | 1 | Recorded direction |
| log_secure | output | 1 | Recorded secure attribute |
| log_priv | output | 1 | Recorded privileged attribute |

## Verification
The properties assume a reset has been applied and that configuration fields and access attributes are plain 0/1 values. They also assume `cfg_region` and `cfg_field` may hold any value, including out-of-range ones. The stimulus drives every input on the falling edge, holds it for one full cycle, and returns the strobes low between operations, so each access and each write is seen on exactly one rising edge. Out-of-range window indices include one whose low bits alias a real window, so a truncated compare would be exposed through the access answers.

// File: rtl/fw_pkg.sv
package fw_pkg;
   localparam int ID_W     = 8;
   localparam int RIGHTS_W = 16;
   localparam int FIELD_W  = 3;

   localparam logic [FIELD_W-1:0] FLD_LO    = 3'd0;
   localparam logic [FIELD_W-1:0] FLD_HI    = 3'd1;
   localparam logic [FIELD_W-1:0] FLD_CTRL  = 3'd2;
   localparam int                 FLD_SLOT0 = 3;

   localparam int CTRL_EN = 0;
   localparam int CTRL_BG = 1;

   typedef struct packed {
      logic write;
      logic secure;
      logic priv;
      logic cache;
      logic debug;
   } acc_attr_t;

   // nibble index: 0 sec-priv, 1 sec-user, 2 nonsec-priv, 3 nonsec-user
   function automatic logic [1:0] nibble_index(input acc_attr_t a);
      return {~a.secure, ~a.priv};
   endfunction

   // bit0 write, bit1 read, bit2 cacheable, bit3 debug
   function automatic logic [3:0] needed_bits(input acc_attr_t a);
      return {a.debug, a.cache, ~a.write, a.write};
   endfunction
endpackage

// File: rtl/fw_region_store.sv
module fw_region_store
   import fw_pkg::*;
#(
   parameter int N_REGIONS = 3,
   parameter int N_SLOTS   = 3,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CFG_IDX_W = 4
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          cfg_we,
   input  logic [CFG_IDX_W-1:0]                          cfg_region,
   input  logic [FIELD_W-1:0]                            cfg_field,
   input  logic [DATA_W-1:0]                             cfg_wdata,
   output logic                                          cfg_err,
   output logic [N_REGIONS-1:0][ADDR_W-1:0]              lo_q,
   output logic [N_REGIONS-1:0][ADDR_W-1:0]              hi_q,
   output logic [N_REGIONS-1:0]                          en_q,
   output logic [N_REGIONS-1:0]                          bg_q,
   output logic [N_REGIONS-1:0][N_SLOTS-1:0][ID_W-1:0]     slot_id_q,
   output logic [N_REGIONS-1:0][N_SLOTS-1:0][RIGHTS_W-1:0] slot_rights_q
);
   localparam logic [CFG_IDX_W:0] REG_LIMIT = (CFG_IDX_W+1)'(N_REGIONS);
   localparam logic [FIELD_W:0]   FLD_LIMIT = (FIELD_W+1)'(FLD_SLOT0 + N_SLOTS);

   logic idx_ok, fld_ok, accept;
   assign idx_ok = {1'b0, cfg_region} < REG_LIMIT;
   assign fld_ok = {1'b0, cfg_field} < FLD_LIMIT;
   assign accept = cfg_we && idx_ok && fld_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= cfg_we && !(idx_ok && fld_ok);
   end

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
      localparam logic [CFG_IDX_W-1:0] RID = CFG_IDX_W'(r);
      logic sel;
      assign sel = accept && (cfg_region == RID);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[r] <= '0;
            hi_q[r] <= '0;
            en_q[r] <= 1'b0;
            bg_q[r] <= 1'b0;
         end else if (sel) begin
            if (cfg_field == FLD_LO) lo_q[r] <= cfg_wdata[ADDR_W-1:0];
            if (cfg_field == FLD_HI) hi_q[r] <= cfg_wdata[ADDR_W-1:0];
            if (cfg_field == FLD_CTRL) begin
               en_q[r] <= cfg_wdata[CTRL_EN];
               bg_q[r] <= cfg_wdata[CTRL_BG];
            end
         end
      end

      for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
         localparam logic [FIELD_W-1:0] FSLOT = FIELD_W'(FLD_SLOT0 + s);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_id_q[r][s]     <= '0;
               slot_rights_q[r][s] <= '0;
            end else if (sel && cfg_field == FSLOT) begin
               slot_id_q[r][s]     <= cfg_wdata[RIGHTS_W +: ID_W];
               slot_rights_q[r][s] <= cfg_wdata[RIGHTS_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/fw_region_eval.sv
module fw_region_eval
   import fw_pkg::*;
#(
   parameter int N_SLOTS = 3,
   parameter int ADDR_W  = 32
) (
   input  logic [ADDR_W-1:0]                 lo,
   input  logic [ADDR_W-1:0]                 hi,
   input  logic                              en,
   input  logic [N_SLOTS-1:0][ID_W-1:0]      slot_id,
   input  logic [N_SLOTS-1:0][RIGHTS_W-1:0]  slot_rights,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [ID_W-1:0]                   id,
   input  acc_attr_t                         attr,
   output logic                              hit,
   output logic                              allow
);
   logic [1:0]         nsel;
   logic [3:0]         need;
   logic [N_SLOTS-1:0] slot_ok;

   assign hit  = en && (addr >= lo) && (addr <= hi);
   assign nsel = nibble_index(attr);
   assign need = needed_bits(attr);

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      logic [3:0] nib;
      assign nib        = slot_rights[s][{nsel, 2'b00} +: 4];
      assign slot_ok[s] = (slot_id[s] == id) && ((nib & need) == need);
   end

   assign allow = |slot_ok;
endmodule

// File: rtl/fw_priority_pick.sv
module fw_priority_pick #(
   parameter int N_REGIONS = 3
) (
   input  logic [N_REGIONS-1:0] hit,
   input  logic [N_REGIONS-1:0] bg,
   input  logic [N_REGIONS-1:0] allow,
   output logic                 grant
);
   logic fg_found, fg_allow, bg_found, bg_allow;

   always_comb begin
      fg_found = 1'b0;
      fg_allow = 1'b0;
      bg_found = 1'b0;
      bg_allow = 1'b0;
      // walk downward so the lowest index is the last to overwrite
      for (int r = N_REGIONS - 1; r >= 0; r--) begin
         if (hit[r] && !bg[r]) begin
            fg_found = 1'b1;
            fg_allow = allow[r];
         end
         if (hit[r] && bg[r]) begin
            bg_found = 1'b1;
            bg_allow = allow[r];
         end
      end
      if (fg_found)      grant = fg_allow;
      else if (bg_found) grant = bg_allow;
      else               grant = 1'b0;
   end
endmodule

// File: rtl/fw_violation_log.sv
module fw_violation_log
   import fw_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              deny,
   input  logic              clear,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ID_W-1:0]   id,
   input  acc_attr_t         attr,
   output logic              valid,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [ID_W-1:0]   rec_id,
   output logic              rec_write,
   output logic              rec_secure,
   output logic              rec_priv
);
   logic take;
   assign take = deny && (!valid || clear);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid      <= 1'b0;
         rec_addr   <= '0;
         rec_id     <= '0;
         rec_write  <= 1'b0;
         rec_secure <= 1'b0;
         rec_priv   <= 1'b0;
      end else if (take) begin
         valid      <= 1'b1;
         rec_addr   <= addr;
         rec_id     <= id;
         rec_write  <= attr.write;
         rec_secure <= attr.secure;
         rec_priv   <= attr.priv;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/bus_region_firewall.sv
module bus_region_firewall
   import fw_pkg::*;
#(
   parameter int N_REGIONS = 3,
   parameter int N_SLOTS   = 3,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CFG_IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_region,
   input  logic [2:0]           cfg_field,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic                 cfg_err,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [7:0]           req_id,
   input  logic                 req_write,
   input  logic                 req_secure,
   input  logic                 req_priv,
   input  logic                 req_cache,
   input  logic                 req_debug,
   output logic                 dec_valid,
   output logic                 dec_grant,
   output logic                 dec_err,
   input  logic                 log_clear,
   output logic                 log_valid,
   output logic [ADDR_W-1:0]    log_addr,
   output logic [7:0]           log_id,
   output logic                 log_write,
   output logic                 log_secure,
   output logic                 log_priv
);
   if (N_SLOTS < 1 || N_SLOTS > 3) begin : g_bad_slots
      $error("N_SLOTS must lie in 1..3");
   end
   if (N_REGIONS < 1 || N_REGIONS > (1 << CFG_IDX_W)) begin : g_bad_regions
      $error("N_REGIONS must be 1..2**CFG_IDX_W");
   end
   if (DATA_W < ADDR_W || DATA_W < ID_W + RIGHTS_W) begin : g_bad_data
      $error("DATA_W too narrow for address or slot word");
   end

   logic [N_REGIONS-1:0][ADDR_W-1:0]              lo_q, hi_q;
   logic [N_REGIONS-1:0]                          en_q, bg_q;
   logic [N_REGIONS-1:0][N_SLOTS-1:0][ID_W-1:0]     slot_id_q;
   logic [N_REGIONS-1:0][N_SLOTS-1:0][RIGHTS_W-1:0] slot_rights_q;
   logic [N_REGIONS-1:0] hit, allow;
   logic                 grant_c, deny_c;
   acc_attr_t            attr;

   assign attr = '{write: req_write, secure: req_secure, priv: req_priv,
                   cache: req_cache, debug: req_debug};

   fw_region_store #(
      .N_REGIONS(N_REGIONS), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .CFG_IDX_W(CFG_IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
      .lo_q(lo_q), .hi_q(hi_q), .en_q(en_q), .bg_q(bg_q),
      .slot_id_q(slot_id_q), .slot_rights_q(slot_rights_q)
   );

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_eval
      fw_region_eval #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_eval (
         .lo(lo_q[r]), .hi(hi_q[r]), .en(en_q[r]),
         .slot_id(slot_id_q[r]), .slot_rights(slot_rights_q[r]),
         .addr(req_addr), .id(req_id), .attr(attr),
         .hit(hit[r]), .allow(allow[r])
      );
   end

   fw_priority_pick #(.N_REGIONS(N_REGIONS)) u_pick (
      .hit(hit), .bg(bg_q), .allow(allow), .grant(grant_c)
   );

   assign deny_c = req_valid && !grant_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_grant <= 1'b0;
         dec_err   <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_grant <= req_valid && grant_c;
         dec_err   <= deny_c;
      end
   end

   fw_violation_log #(.ADDR_W(ADDR_W)) u_log (
      .clk(clk), .rst_n(rst_n), .deny(deny_c), .clear(log_clear),
      .addr(req_addr), .id(req_id), .attr(attr),
      .valid(log_valid), .rec_addr(log_addr), .rec_id(log_id),
      .rec_write(log_write), .rec_secure(log_secure), .rec_priv(log_priv)
   );
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
   parameter int N_REGIONS = 3,
   parameter int N_SLOTS   = 3,
   parameter int ADDR_W    = 32,
   parameter int CFG_IDX_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [CFG_IDX_W-1:0] cfg_region,
   input logic [2:0]           cfg_field,
   input logic                 cfg_err,
   input logic                 req_valid,
   input logic                 dec_valid,
   input logic                 dec_grant,
   input logic                 dec_err,
   input logic                 log_clear,
   input logic                 log_valid,
   input logic [ADDR_W-1:0]    log_addr
);
   localparam logic [CFG_IDX_W:0] REG_LIMIT = (CFG_IDX_W+1)'(N_REGIONS);
   localparam logic [3:0]         FLD_LIMIT = 4'(3 + N_SLOTS);

   logic bad_cfg;
   assign bad_cfg = ({1'b0, cfg_region} >= REG_LIMIT) || ({1'b0, cfg_field} >= FLD_LIMIT);

   a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(dec_valid || dec_grant || dec_err));
   a_r2_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $countones({dec_grant, dec_err}) == 1);
   a_r10_bad_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && bad_cfg |=> cfg_err);
   a_r10_good_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && bad_cfg) |=> !cfg_err);
   a_r11_refusal_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err |-> log_valid);
   a_r11_record_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && !log_clear |=> log_valid && $stable(log_addr));
   a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      log_clear && !req_valid |=> !log_valid);
endmodule

bind bus_region_firewall fw_checker #(
   .N_REGIONS(N_REGIONS), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .CFG_IDX_W(CFG_IDX_W)
) u_fw_checker (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
   .cfg_field(cfg_field), .cfg_err(cfg_err), .req_valid(req_valid),
   .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_err(dec_err),
   .log_clear(log_clear), .log_valid(log_valid), .log_addr(log_addr)
);

// File: tb/bus_region_firewall_tb_top.sv
`timescale 1ns/1ps
module bus_region_firewall_tb_top;
   localparam int CFG_IDX_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [CFG_IDX_W-1:0] cfg_region = '0;
   logic [2:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_err;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_id = '0;
   logic        req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
   logic        req_cache = 1'b0, req_debug = 1'b0;
   logic        dec_valid, dec_grant, dec_err;
   logic        log_clear = 1'b0;
   logic        log_valid;
   logic [31:0] log_addr;
   logic [7:0]  log_id;
   logic        log_write, log_secure, log_priv;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;
   bit    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   bus_region_firewall #(.N_REGIONS(3), .N_SLOTS(3), .ADDR_W(32), .DATA_W(32),
                         .CFG_IDX_W(CFG_IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
      .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id),
      .req_write(req_write), .req_secure(req_secure), .req_priv(req_priv),
      .req_cache(req_cache), .req_debug(req_debug),
      .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_err(dec_err),
      .log_clear(log_clear), .log_valid(log_valid), .log_addr(log_addr),
      .log_id(log_id), .log_write(log_write), .log_secure(log_secure),
      .log_priv(log_priv)
   );

   task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per answer
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (exp_q.size() == 0) begin
            check_val("R2 unexpected answer", 32'(dec_valid), 32'd0);
         end else begin
            automatic bit    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check_val(t, {30'd0, dec_grant, dec_err}, {30'd0, e, ~e});
         end
      end
   end

   task automatic drive_req(input logic [31:0] a, input logic [7:0] id, input bit w,
                            input bit s, input bit p, input bit c, input bit d,
                            input bit exp, input string tag);
      req_valid = 1'b1; req_addr = a; req_id = id; req_write = w;
      req_secure = s; req_priv = p; req_cache = c; req_debug = d;
      exp_q.push_back(exp); tag_q.push_back(tag);
   endtask

   task automatic do_req(input logic [31:0] a, input logic [7:0] id, input bit w,
                         input bit s, input bit p, input bit c, input bit d,
                         input bit exp, input string tag);
      @(negedge clk);
      drive_req(a, id, w, s, p, c, d, exp, tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_cfg(input logic [CFG_IDX_W-1:0] r, input logic [2:0] f,
                         input logic [31:0] d, input bit exp_err, input string tag);
      @(negedge clk);
      cfg_we = 1'b1; cfg_region = r; cfg_field = f; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      check_val(tag, 32'(cfg_err), 32'(exp_err));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1 log empty after reset", 32'(log_valid), 32'd0);
      check_val("R1 no answer after reset", 32'(dec_valid), 32'd0);
      do_req(32'h1000, 8'h61, 0, 1, 1, 0, 0, 0, "R1 reset denies");
      check_val("R11 record valid", 32'(log_valid), 32'd1);
      check_val("R11 record addr", log_addr, 32'h1000);
      check_val("R11 record id", 32'(log_id), 32'h61);
      check_val("R11 record attrs", {29'd0, log_write, log_secure, log_priv}, 32'b011);

      // window 0: foreground, 256 bytes, slot word: ID 23:16, rights 15:0
      do_cfg(0, 3'd0, 32'h4211_0000, 0, "R10 good lo write");
      do_cfg(0, 3'd1, 32'h4211_00FF, 0, "R10 good hi write");
      do_cfg(0, 3'd3, 32'h0061_FFFF, 0, "R10 good slot write");
      do_req(32'h4211_0000, 8'h61, 0, 1, 1, 0, 0, 0, "R8 disabled window matches nothing");
      do_cfg(0, 3'd2, 32'h1, 0, "R10 good ctrl write");
      do_req(32'h4211_0000, 8'h61, 0, 1, 1, 0, 0, 1, "R3 lower bound inside");
      do_req(32'h4211_00FF, 8'h61, 1, 0, 0, 1, 1, 1, "R3 upper bound inside");
      do_req(32'h4210_FFFF, 8'h61, 0, 1, 1, 0, 0, 0, "R3 below lower bound");
      do_req(32'h4211_0100, 8'h61, 0, 1, 1, 0, 0, 0, "R3 above upper bound");
      do_req(32'h4211_0010, 8'h62, 0, 1, 1, 0, 0, 0, "R4 foreign id refused");
      check_val("R11 first refusal kept", log_addr, 32'h1000);

      @(negedge clk); log_clear = 1'b1;
      @(negedge clk); log_clear = 1'b0;
      check_val("R12 clear empties", 32'(log_valid), 32'd0);
      @(negedge clk);
      log_clear = 1'b1;
      drive_req(32'h0000_0055, 8'h12, 1, 0, 0, 0, 0, 0, "R12 refusal during clear");
      @(negedge clk);
      log_clear = 1'b0; req_valid = 1'b0;
      check_val("R12 refusal during clear recorded", log_addr, 32'h55);
      check_val("R12 record valid", 32'(log_valid), 32'd1);

      // rights nibbles
      do_cfg(0, 3'd3, 32'h0061_0002, 0, "R5 slot sec-priv read only");
      do_req(32'h4211_0020, 8'h61, 0, 1, 1, 0, 0, 1, "R5 sec-priv read");
      do_req(32'h4211_0020, 8'h61, 1, 1, 1, 0, 0, 0, "R5 sec-priv write refused");
      do_req(32'h4211_0020, 8'h61, 0, 1, 0, 0, 0, 0, "R5 sec-user read refused");
      do_req(32'h4211_0020, 8'h61, 0, 0, 1, 0, 0, 0, "R5 nonsec-priv read refused");
      do_cfg(0, 3'd3, 32'h0061_6000, 0, "R5 slot nonsec-user read+cache");
      do_req(32'h4211_0020, 8'h61, 0, 0, 0, 1, 0, 1, "R5 nonsec-user cacheable read");
      do_req(32'h4211_0020, 8'h61, 0, 0, 0, 0, 0, 1, "R5 nonsec-user plain read");
      do_req(32'h4211_0020, 8'h61, 0, 0, 0, 1, 1, 0, "R5 debug bit missing");
      do_req(32'h4211_0020, 8'h61, 1, 0, 0, 0, 0, 0, "R5 nonsec-user write refused");
      do_cfg(0, 3'd4, 32'h0070_FFFF, 0, "R4 second slot write");
      do_req(32'h4211_0020, 8'h70, 1, 1, 1, 0, 0, 1, "R4 second slot grants");

      // window 1: background over a wider range
      do_cfg(1, 3'd0, 32'h4211_0000, 0, "R10 bg lo");
      do_cfg(1, 3'd1, 32'h4211_FFFF, 0, "R10 bg hi");
      do_cfg(1, 3'd3, 32'h0033_FFFF, 0, "R10 bg slot");
      do_cfg(1, 3'd2, 32'h3, 0, "R10 bg ctrl");
      do_req(32'h4211_0010, 8'h33, 0, 1, 1, 0, 0, 0, "R6 foreground hides background");
      do_req(32'h4211_0200, 8'h33, 0, 1, 1, 0, 0, 1, "R6 background alone grants");
      do_req(32'h4211_0200, 8'h61, 0, 1, 1, 0, 0, 0, "R6 background alone refuses");

      // window 2: foreground overlapping window 0
      do_cfg(2, 3'd0, 32'h4211_0080, 0, "R10 fg2 lo");
      do_cfg(2, 3'd1, 32'h4211_00FF, 0, "R10 fg2 hi");
      do_cfg(2, 3'd3, 32'h0033_FFFF, 0, "R10 fg2 slot");
      do_cfg(2, 3'd2, 32'h1, 0, "R10 fg2 ctrl");
      do_req(32'h4211_0090, 8'h33, 0, 1, 1, 0, 0, 0, "R7 lower foreground wins refuse");
      do_req(32'h4211_0090, 8'h70, 1, 1, 1, 0, 0, 1, "R7 lower foreground wins grant");
      do_cfg(0, 3'd2, 32'h0, 0, "R8 disable window 0");
      do_req(32'h4211_0090, 8'h33, 0, 1, 1, 0, 0, 1, "R8 disabled window skipped");
      do_req(32'h4211_0010, 8'h33, 0, 1, 1, 0, 0, 1, "R8 falls to background");

      // same-cycle write and access
      @(negedge clk);
      cfg_we = 1'b1; cfg_region = 2; cfg_field = 3'd3; cfg_wdata = 32'h0044_FFFF;
      drive_req(32'h4211_0090, 8'h33, 0, 1, 1, 0, 0, 1, "R9 same cycle uses old");
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      do_req(32'h4211_0090, 8'h33, 0, 1, 1, 0, 0, 0, "R9 next cycle uses new refuse");
      do_req(32'h4211_0090, 8'h44, 0, 1, 1, 0, 0, 1, "R9 next cycle uses new grant");

      // rejected writes
      do_cfg(3, 3'd2, 32'h1, 1, "R10 index at limit");
      do_cfg(2, 3'd6, 32'h0055_FFFF, 1, "R10 field code 6");
      do_cfg(2, 3'd7, 32'h0055_FFFF, 1, "R10 field code 7");
      do_cfg(6, 3'd3, 32'h0055_FFFF, 1, "R10 aliasing index");
      do_req(32'h4211_0090, 8'h55, 0, 1, 1, 0, 0, 0, "R10 rejected write had no effect");
      do_req(32'h4211_0090, 8'h44, 0, 1, 1, 0, 0, 1, "R10 window 2 unchanged");

      repeat (3) @(negedge clk);
      check_val("R2 all answers seen", exp_q.size(), 32'd0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule